// File: doc/BRIEF.md
# Multi-Ratio Serializer with Parity Check

This block turns a parallel word into a serial bit stream, one bit per enabled bit-clock cycle. Four ratios are supported: 16:1, 10:1, 8:1 and 4:1. For the three narrower ratios only a centred slice of the 16-lane input bus carries data, and the remaining lanes are ignored. The bit order is most-significant-active-lane first in every mode except 10:1, which sends the least significant active lane first. A parity bit travels with each word. It is checked against the active lanes under either odd or even sense, and a flag reports a mismatch for the word it belongs to.

Words enter through a valid/ready handshake. The block raises `in_ready` only in the bit-clock cycle in which the last bit of the current word leaves, or at the first enabled cycle after reset. The source therefore cannot push faster than the line drains, and back-pressure is simply the absence of `in_ready`. If no word is offered at a boundary, the block sends a slot of zeros so that the line timing never slips. The ratio select and parity sense are sampled only when a slot starts, so they can be changed at any time without disturbing a word in flight.

Top module: `mr_serializer`

## Requirements
- R1: `ratio_sel` encodes 0 = 16:1, 1 = 10:1, 2 = 8:1, 3 = 4:1. A slot started under a ratio lasts exactly that many enabled bit-clock cycles. The stored ratio resets to code 0 (16:1).
- R2: The active lanes are 0..15 at 16:1, 3..12 at 10:1, 4..11 at 8:1 and 6..9 at 4:1. Data on other lanes never appears on `ser_out`.
- R3: At 16:1, 8:1 and 4:1 the highest active lane is sent first and the lowest active lane last.
- R4: At 10:1 lane 3 is sent first and lane 12 last.
- R5: `in_ready` is high exactly in cycles with `bit_en` high in which the last bit of the current slot is on `ser_out`, or no slot has started since reset. A word is taken when `in_valid` and `in_ready` are both high, and its first bit is on `ser_out` after that clock edge.
- R6: If `in_valid` is low in a ready cycle, a slot of zeros of the selected length is sent, `word_stb` stays low and `par_err` is low for that slot.
- R7: `word_stb` goes high at the edge that accepts a word and falls at the next edge with `bit_en` high that does not accept another word.
- R8: With `par_odd` = 1, a word is in error when the count of ones over its active lanes plus `in_par` is even. With `par_odd` = 0, it is in error when that count is odd. Inactive lanes do not count.
- R9: `par_err` is updated at each slot start and held unchanged until the next slot start.
- R10: Changes of `ratio_sel`, `par_odd`, `in_data` or `in_par` outside an accepting cycle have no effect on the slot in progress.
- R11: During and right after reset, `ser_out`, `word_stb` and `par_err` are low.
- R12: In cycles with `bit_en` low, `ser_out` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Bit-rate enable, one serial bit per high cycle |
| in_valid | input | 1 | Source offers a word |
| in_ready | output | 1 | Block takes a word this cycle |
| in_data | input | 16 | Parallel word, lanes 0..15 |
| in_par | input | 1 | Parity bit of the word |
| ratio_sel | input | 2 | Serialization ratio code |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| ser_out | output | 1 | Serial data |
| word_stb | output | 1 | Strobe marking an accepted word |
| par_err | output | 1 | Parity mismatch of the current slot |

## Verification
Two functions meet in the same cycle at every word boundary: a new ratio and parity sense are latched, and the parity verdict of the incoming word is formed. The bench changes the ratio on nearly every word and mixes matching and mismatching parity bits, so both events fall on the accepting edge. It then judges the outcome in two ways. The length of the next slot shows up in when `in_ready` returns, and the flag is compared against an arithmetic parity over that ratio's lanes. Between boundaries the bench drives garbage on every sampled input, and varies the enable cadence, to show that nothing outside a boundary leaks into the slot.

// File: rtl/ser_pkg.sv
package ser_pkg;

  typedef enum logic [1:0] {
    RATIO_16 = 2'd0,
    RATIO_10 = 2'd1,
    RATIO_8  = 2'd2,
    RATIO_4  = 2'd3
  } ratio_e;

  // active lane count for a ratio code, given the configured widths
  function automatic int active_width(ratio_e r, int full_w, int w_ten, int w_eight, int w_four);
    case (r)
      RATIO_16: return full_w;
      RATIO_10: return w_ten;
      RATIO_8:  return w_eight;
      default:  return w_four;
    endcase
  endfunction

endpackage

// File: rtl/lane_order.sv
module lane_order
  import ser_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int W_TEN   = 10,
  parameter int W_EIGHT = 8,
  parameter int W_FOUR  = 4
) (
  input  logic [WORD_W-1:0] din,
  input  ratio_e            ratio,
  output logic [WORD_W-1:0] seq,
  output logic [WORD_W-1:0] mask
);

  // Each mode builds a left-justified vector in transmission order:
  // bit WORD_W-1 goes out first.
  for (genvar m = 0; m < 4; m++) begin : g_mode
    localparam int W  = (m == 0) ? WORD_W : (m == 1) ? W_TEN : (m == 2) ? W_EIGHT : W_FOUR;
    localparam int LO = (WORD_W - W) / 2;
    logic [WORD_W-1:0] seq_m;
    logic [WORD_W-1:0] msk_m;
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      if (b >= WORD_W - W) begin : g_on
        localparam int POS = WORD_W - 1 - b;
        if (m == int'(RATIO_10)) begin : g_rev
          assign seq_m[b] = din[LO + POS];
        end else begin : g_fwd
          assign seq_m[b] = din[LO + W - 1 - POS];
        end
      end else begin : g_off
        assign seq_m[b] = 1'b0;
      end
      if (b >= LO && b < LO + W) begin : g_in
        assign msk_m[b] = 1'b1;
      end else begin : g_out
        assign msk_m[b] = 1'b0;
      end
    end
  end

  always_comb begin
    unique case (ratio)
      RATIO_16: begin seq = g_mode[0].seq_m; mask = g_mode[0].msk_m; end
      RATIO_10: begin seq = g_mode[1].seq_m; mask = g_mode[1].msk_m; end
      RATIO_8:  begin seq = g_mode[2].seq_m; mask = g_mode[2].msk_m; end
      default:  begin seq = g_mode[3].seq_m; mask = g_mode[3].msk_m; end
    endcase
  end

endmodule

// File: rtl/par_check.sv
module par_check #(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] din,
  input  logic [WORD_W-1:0] mask,
  input  logic              par_bit,
  input  logic              odd_sense,
  output logic              mismatch
);

  logic ones_odd;

  assign ones_odd = (^(din & mask)) ^ par_bit;
  // even sense wants an even total, odd sense an odd total
  assign mismatch = odd_sense ? ~ones_odd : ones_odd;

endmodule

// File: rtl/ser_shift.sv
module ser_shift
  import ser_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int W_TEN   = 10,
  parameter int W_EIGHT = 8,
  parameter int W_FOUR  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  ratio_e            load_ratio,
  output logic              ser_out,
  output logic              at_bound
);

  localparam int CW = $clog2(WORD_W);

  logic [WORD_W-1:0] sreg;
  logic [CW-1:0]     cnt;
  ratio_e            ratio_q;

  function automatic logic [CW-1:0] last_of(ratio_e r);
    return CW'(active_width(r, WORD_W, W_TEN, W_EIGHT, W_FOUR) - 1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg    <= '0;
      cnt     <= '0;
      ratio_q <= RATIO_16;
    end else if (load) begin
      sreg    <= load_word;
      cnt     <= last_of(load_ratio);
      ratio_q <= load_ratio;
    end else if (bit_en) begin
      sreg <= {sreg[WORD_W-2:0], 1'b0};
      if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  assign ser_out  = sreg[WORD_W-1];
  assign at_bound = (cnt == '0);

  // R12: the line only moves on enabled cycles
  p_hold_no_en_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(ser_out));

  // R10: the latched ratio only changes at a slot start
  p_ratio_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(ratio_q));

  // R1: the remaining-bit count never exceeds the latched slot length
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last_of(ratio_q));

endmodule

// File: rtl/mr_serializer.sv
module mr_serializer
  import ser_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int W_TEN   = 10,
  parameter int W_EIGHT = 8,
  parameter int W_FOUR  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_par,
  input  logic [1:0]        ratio_sel,
  input  logic              par_odd,
  output logic              ser_out,
  output logic              word_stb,
  output logic              par_err
);

  ratio_e            ratio_in;
  logic [WORD_W-1:0] seq_w;
  logic [WORD_W-1:0] mask_w;
  logic              mism;
  logic              at_bound;
  logic [WORD_W-1:0] load_word;

  assign ratio_in  = ratio_e'(ratio_sel);
  assign in_ready  = bit_en & at_bound;
  assign load_word = in_valid ? seq_w : '0;

  lane_order #(.WORD_W(WORD_W), .W_TEN(W_TEN), .W_EIGHT(W_EIGHT), .W_FOUR(W_FOUR)) u_lanes (
    .din   (in_data),
    .ratio (ratio_in),
    .seq   (seq_w),
    .mask  (mask_w)
  );

  par_check #(.WORD_W(WORD_W)) u_par (
    .din       (in_data),
    .mask      (mask_w),
    .par_bit   (in_par),
    .odd_sense (par_odd),
    .mismatch  (mism)
  );

  ser_shift #(.WORD_W(WORD_W), .W_TEN(W_TEN), .W_EIGHT(W_EIGHT), .W_FOUR(W_FOUR)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .load       (in_ready),
    .load_word  (load_word),
    .load_ratio (ratio_in),
    .ser_out    (ser_out),
    .at_bound   (at_bound)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_stb <= 1'b0;
      par_err  <= 1'b0;
    end else if (in_ready) begin
      word_stb <= in_valid;
      par_err  <= in_valid & mism;
    end else if (bit_en) begin
      word_stb <= 1'b0;
    end
  end

  // R7: a rising strobe always follows an accepted word
  p_stb_from_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_stb) |-> $past(in_valid && in_ready));

  // R7: an enabled cycle without acceptance drops the strobe
  p_stb_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !in_ready) |=> !word_stb);

  // R9: the flag is held between slot starts
  p_perr_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(par_err));

endmodule

// File: tb/tb_mr_serializer.sv
module tb_mr_serializer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_en;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_data;
  logic        in_par;
  logic [1:0]  ratio_sel;
  logic        par_odd;
  logic        ser_out;
  logic        word_stb;
  logic        par_err;

  always #4 clk = ~clk;

  mr_serializer dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_par(in_par), .ratio_sel(ratio_sel), .par_odd(par_odd),
    .ser_out(ser_out), .word_stb(word_stb), .par_err(par_err)
  );

  localparam int NWORDS = 120;

  int checks = 0;
  int errors = 0;

  bit [15:0] eb;
  int        exp_len = 16;
  int        pos = 0;
  bit        started = 0;
  bit        exp_stb = 0;
  bit        exp_perr = 0;
  int        cur_r = 0;
  int        cyc_n = 0;
  int        gap = 0;
  int        k = 0;
  int        slot = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int width_of(int r);
    case (r)
      0: return 16;
      1: return 10;
      2: return 8;
      default: return 4;
    endcase
  endfunction

  // transmission order per R2, R3, R4
  function automatic bit [15:0] bits_of(bit [15:0] d, int r);
    int w = width_of(r);
    int lo = (16 - w) / 2;
    bit [15:0] o = '0;
    for (int i = 0; i < w; i++) o[i] = (r == 1) ? d[lo + i] : d[lo + w - 1 - i];
    return o;
  endfunction

  // R8 parity verdict over active lanes only
  function automatic bit perr_of(bit [15:0] d, bit p, int r, bit odd);
    int w = width_of(r);
    int lo = (16 - w) / 2;
    bit x = p;
    for (int i = 0; i < w; i++) x ^= d[lo + i];
    return odd ? !x : x;
  endfunction

  task automatic one_cycle();
    bit        rdy_exp, took, acc, en_s, o_s, p_s;
    bit [15:0] d_s;
    int        r_s;
    @(negedge clk);
    cyc_n++;
    gap = (k / 10) % 3;
    bit_en = ((cyc_n % (gap + 1)) == 0);
    #1;
    rdy_exp = bit_en && (!started || pos == exp_len - 1);
    // R1 slot length and R10 stability show in when ready returns; R5 handshake
    check(in_ready == rdy_exp, "R1 R5 R10 in_ready", int'(in_ready), int'(rdy_exp));
    if (in_ready) begin
      slot++;
      if (k < NWORDS && (slot % 11) != 0) begin
        in_valid  = 1'b1;
        ratio_sel = 2'((k + k / 5) % 4);
        par_odd   = ((k / 3) % 2) == 1;
        if (k % 16 == 0)      in_data = 16'hFFFF;
        else if (k % 16 == 8) in_data = 16'h0000;
        else                  in_data = 16'(k * 40503 + 13 * k * k);
        in_par = in_data[k % 16] ^ ((k % 5) == 0);
        k++;
      end else begin
        in_valid  = 1'b0;
        ratio_sel = 2'(slot % 4);
        in_data   = 16'hA5C3;
        par_odd   = 1'b0;
        in_par    = 1'b1;
      end
    end else begin
      // R10: garbage outside a boundary must not reach the slot
      in_valid  = cyc_n[0];
      in_data   = 16'(cyc_n * 7919);
      ratio_sel = 2'(cyc_n >> 1);
      par_odd   = cyc_n[3];
      in_par    = cyc_n[4];
    end
    took = in_ready;
    acc  = in_ready && in_valid;
    en_s = bit_en;
    d_s  = in_data;
    p_s  = in_par;
    o_s  = par_odd;
    r_s  = int'(ratio_sel);
    @(posedge clk);
    #1;
    if (took) begin
      started  = 1;
      pos      = 0;
      cur_r    = r_s;
      exp_len  = width_of(r_s);
      eb       = acc ? bits_of(d_s, r_s) : 16'h0000;
      exp_stb  = acc;
      exp_perr = acc && perr_of(d_s, p_s, r_s, o_s);
    end else if (en_s) begin
      if (pos < 15) pos++;
      exp_stb = 0;
    end
    if (!took && !en_s)
      check(ser_out == eb[pos], "R12 hold ser_out", int'(ser_out), int'(eb[pos]));
    else if (!exp_stb && took)
      check(ser_out == eb[pos], "R6 idle ser_out", int'(ser_out), int'(eb[pos]));
    else if (cur_r == 1)
      check(ser_out == eb[pos], "R2 R4 ser_out", int'(ser_out), int'(eb[pos]));
    else
      check(ser_out == eb[pos], "R2 R3 ser_out", int'(ser_out), int'(eb[pos]));
    check(word_stb == exp_stb, "R7 word_stb", int'(word_stb), int'(exp_stb));
    check(par_err == exp_perr, "R8 R9 par_err", int'(par_err), int'(exp_perr));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; in_valid = 1'b0; in_data = '0;
    in_par = 1'b0; ratio_sel = 2'd0; par_odd = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    check(ser_out == 1'b0, "R11 ser_out", int'(ser_out), 0);
    check(word_stb == 1'b0, "R11 word_stb", int'(word_stb), 0);
    check(par_err == 1'b0, "R11 par_err", int'(par_err), 0);
    check(in_ready == 1'b0, "R11 in_ready", int'(in_ready), 0);
    rst_n = 1'b1;
    while (k < NWORDS) one_cycle();
    repeat (60) one_cycle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule